// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for an integer instruction sitting in the execute stage of a five-stage in-order pipeline, where each of its two ALU operands must come from. A result that has not yet been written back to the register file may already exist further down the pipe. It may sit in the register after execute, from the instruction one ahead. It may also sit in the register after memory, from the instruction two ahead. In that second case it is the value chosen after the load/ALU result multiplexer, so it covers both loaded data and ALU results.

The block compares each source register number of the execute-stage instruction against the destination number and write flag held in the two later pipeline stages. It produces one 2-bit select per operand for the operand multiplexers. The logic is purely combinational, with no clock and no reset. Its select pins are plain control outputs, not a stream. The destination of the execute-stage instruction is deliberately not an input.

Top module: `opnd_bypass_sel`

## Requirements
- R1: When neither later stage holds a qualifying producer for a source, that operand's select is 2'b00 (register-file value).
- R2: When the post-execute stage has its write flag set, a nonzero destination, and a destination equal to the source, that operand's select is 2'b10.
- R3: When the post-memory stage has its write flag set, a nonzero destination, and a destination equal to the source, and the post-execute stage does not qualify, that operand's select is 2'b01.
- R4: A stage whose write flag is 0 never causes a forward, whatever its destination number.
- R5: A stage whose destination is register 0 never causes a forward, even when the source is also register 0.
- R6: When both later stages qualify for the same source, the newer post-execute result wins (select 2'b10).
- R7: The two operand selects follow identical rules, each depending only on its own source number. The code 2'b11 never appears.
- R8: The selects follow input changes without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_i | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b_i | input | 5 | Second source register number of the execute-stage instruction |
| mem_dst_i | input | 5 | Destination register held after the execute stage |
| mem_wen_i | input | 1 | Register-write flag held after the execute stage |
| wb_dst_i | input | 5 | Destination register held after the memory stage |
| wb_wen_i | input | 1 | Register-write flag held after the memory stage |
| fwd_sel_a_o | output | 2 | First operand select: 00 register file, 01 write-back value, 10 post-execute ALU result |
| fwd_sel_b_o | output | 2 | Second operand select, same encoding |

## Verification
The block holds no state, so any fault in its comparison or priority logic shows on the select pins within the same settle time as the input change that exposes it. A wrong select would show as a stale register-file operand (00 where a forward was due), or as an operand taken from an older or discarded result (01 instead of 10, or any forward from register 0 or from a non-writing stage). The bench sweeps every combination of a small set of register numbers (0, 1, 2, 3, 31) across both sources, both destinations and both write flags, so every priority and exclusion case is reached.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/opbyp_producer_match.sv
module opbyp_producer_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             wen_i,
  output logic             hit_o
);
  logic dst_nonzero;
  logic num_equal;

  assign dst_nonzero = |dst_i;
  assign num_equal   = (src_i == dst_i);
  assign hit_o       = wen_i & dst_nonzero & num_equal;
endmodule

// File: rtl/opbyp_sel_resolve.sv
module opbyp_sel_resolve
  import opbyp_pkg::*;
(
  input  logic     mem_hit_i,
  input  logic     wb_hit_i,
  output fwd_sel_e sel_o
);
  always_comb begin
    if (mem_hit_i)     sel_o = SEL_MEM;
    else if (wb_hit_i) sel_o = SEL_WB;
    else               sel_o = SEL_REGFILE;
  end
endmodule

// File: rtl/opnd_bypass_sel.sv
module opnd_bypass_sel
  import opbyp_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_src_a_i,
  input  logic [REG_W-1:0] ex_src_b_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_wen_i,
  input  logic [REG_W-1:0] wb_dst_i,
  input  logic             wb_wen_i,
  output logic [1:0]       fwd_sel_a_o,
  output logic [1:0]       fwd_sel_b_o
);
  localparam int NUM_OPND = 2;

  logic [REG_W-1:0] src_arr [NUM_OPND];
  fwd_sel_e         sel_arr [NUM_OPND];

  assign src_arr[0] = ex_src_a_i;
  assign src_arr[1] = ex_src_b_i;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    logic mem_hit;
    logic wb_hit;

    opbyp_producer_match #(.REG_W(REG_W)) u_mem_match (
      .src_i (src_arr[g]),
      .dst_i (mem_dst_i),
      .wen_i (mem_wen_i),
      .hit_o (mem_hit)
    );

    opbyp_producer_match #(.REG_W(REG_W)) u_wb_match (
      .src_i (src_arr[g]),
      .dst_i (wb_dst_i),
      .wen_i (wb_wen_i),
      .hit_o (wb_hit)
    );

    opbyp_sel_resolve u_resolve (
      .mem_hit_i (mem_hit),
      .wb_hit_i  (wb_hit),
      .sel_o     (sel_arr[g])
    );
  end

  assign fwd_sel_a_o = sel_arr[0];
  assign fwd_sel_b_o = sel_arr[1];
endmodule

// File: rtl/opnd_bypass_sel_chk.sv
module opnd_bypass_sel_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] ex_src_a_i,
  input logic [REG_W-1:0] ex_src_b_i,
  input logic [REG_W-1:0] mem_dst_i,
  input logic             mem_wen_i,
  input logic [REG_W-1:0] wb_dst_i,
  input logic             wb_wen_i,
  input logic [1:0]       fwd_sel_a_o,
  input logic [1:0]       fwd_sel_b_o
);
  logic mem_ok, wb_ok;
  assign mem_ok = mem_wen_i && (mem_dst_i != '0);
  assign wb_ok  = wb_wen_i  && (wb_dst_i  != '0);

  always_comb begin
    // R1: nothing qualifies -> register file
    if (!(mem_ok && mem_dst_i == ex_src_a_i) && !(wb_ok && wb_dst_i == ex_src_a_i))
      a_r1_idle_a: assert (fwd_sel_a_o == 2'b00) else $error("a_r1_idle_a");
    // R2 / R6: post-execute match wins regardless of post-memory stage
    if (mem_ok && mem_dst_i == ex_src_b_i)
      a_r6_newer_wins_b: assert (fwd_sel_b_o == 2'b10) else $error("a_r6_newer_wins_b");
    // R3: only post-memory stage qualifies
    if (!(mem_ok && mem_dst_i == ex_src_a_i) && wb_ok && wb_dst_i == ex_src_a_i)
      a_r3_wb_only_a: assert (fwd_sel_a_o == 2'b01) else $error("a_r3_wb_only_a");
    // R4: no writer anywhere -> no forward on either operand
    if (!mem_wen_i && !wb_wen_i)
      a_r4_no_writer: assert (fwd_sel_a_o == 2'b00 && fwd_sel_b_o == 2'b00)
        else $error("a_r4_no_writer");
    // R5: both destinations are register 0 -> no forward
    if (mem_dst_i == '0 && wb_dst_i == '0)
      a_r5_zero_dst: assert (fwd_sel_a_o == 2'b00 && fwd_sel_b_o == 2'b00)
        else $error("a_r5_zero_dst");
    // R7: same source number gives the same select; code 11 never used
    if (ex_src_a_i == ex_src_b_i)
      a_r7_symmetric: assert (fwd_sel_a_o == fwd_sel_b_o) else $error("a_r7_symmetric");
    a_r7_no_code3: assert (fwd_sel_a_o != 2'b11 && fwd_sel_b_o != 2'b11)
      else $error("a_r7_no_code3");
  end
endmodule

bind opnd_bypass_sel opnd_bypass_sel_chk #(.REG_W(REG_W)) u_chk (
  .ex_src_a_i  (ex_src_a_i),
  .ex_src_b_i  (ex_src_b_i),
  .mem_dst_i   (mem_dst_i),
  .mem_wen_i   (mem_wen_i),
  .wb_dst_i    (wb_dst_i),
  .wb_wen_i    (wb_wen_i),
  .fwd_sel_a_o (fwd_sel_a_o),
  .fwd_sel_b_o (fwd_sel_b_o)
);

// File: tb/sim_opnd_bypass_sel.sv
`timescale 1ns/1ps
module sim_opnd_bypass_sel;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] src_a, src_b, mdst, wdst;
  logic       mwen, wwen;
  logic [1:0] sel_a, sel_b;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  opnd_bypass_sel u0 (
    .ex_src_a_i (src_a), .ex_src_b_i (src_b),
    .mem_dst_i (mdst), .mem_wen_i (mwen),
    .wb_dst_i (wdst), .wb_wen_i (wwen),
    .fwd_sel_a_o (sel_a), .fwd_sel_b_o (sel_b)
  );

  function automatic logic [1:0] model(logic [4:0] s);
    if (mwen && mdst != 0 && mdst == s) return 2'b10;
    if (wwen && wdst != 0 && wdst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_of(logic [4:0] s);
    if (mwen && mdst != 0 && mdst == s)
      return (wwen && wdst != 0 && wdst == s) ? "R6" : "R2";
    if (wwen && wdst != 0 && wdst == s) return "R3";
    if ((mdst == s && !mwen) || (wdst == s && !wwen)) return "R4";
    if ((mdst == s || wdst == s) && s == 0) return "R5";
    return "R1";
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (a=%0d b=%0d m=%0d/%b w=%0d/%b)",
               tag, act, exp, src_a, src_b, mdst, mwen, wdst, wwen);
    end
  endtask

  task automatic apply(logic [4:0] a, logic [4:0] b, logic [4:0] md, logic mw,
                       logic [4:0] wd, logic ww);
    src_a = a; src_b = b; mdst = md; mwen = mw; wdst = wd; wwen = ww;
    #2;
  endtask

  initial begin : main
    logic [4:0] vals [5];
    vals[0] = 5'd0; vals[1] = 5'd1; vals[2] = 5'd2; vals[3] = 5'd3; vals[4] = 5'd31;
    @(negedge clk);
    // all-zero inputs: register 0 everywhere, no forward (R5)
    apply(0, 0, 0, 1'b1, 0, 1'b1);
    chk("R5", sel_a, 2'b00); chk("R5", sel_b, 2'b00);
    // both operands match post-execute stage (R2)
    apply(8, 8, 8, 1'b1, 4, 1'b1);
    chk("R2", sel_a, 2'b10); chk("R2", sel_b, 2'b10);
    // one matches post-memory, the other unmatched (R3, R1)
    apply(8, 12, 4, 1'b1, 8, 1'b1);
    chk("R3", sel_a, 2'b01); chk("R1", sel_b, 2'b00);
    // write flag 0 on a matching stage (R4)
    apply(9, 9, 9, 1'b0, 9, 1'b0);
    chk("R4", sel_a, 2'b00); chk("R4", sel_b, 2'b00);
    // both stages match, newer wins (R6)
    apply(6, 6, 6, 1'b1, 6, 1'b1);
    chk("R6", sel_a, 2'b10); chk("R6", sel_b, 2'b10);
    // independent operands: a from post-execute, b from post-memory (R7)
    apply(10, 11, 10, 1'b1, 11, 1'b1);
    chk("R7", sel_a, 2'b10); chk("R7", sel_b, 2'b01);
    // change mid-cycle, no clock edge between (R8)
    @(posedge clk); #1;
    src_b = 10; #1;
    chk("R8", sel_b, 2'b10);
    @(negedge clk);
    // near-exhaustive sweep over a small register set
    for (int ia = 0; ia < 5; ia++)
      for (int ib = 0; ib < 5; ib++)
        for (int im = 0; im < 5; im++)
          for (int iw = 0; iw < 5; iw++)
            for (int f = 0; f < 4; f++) begin
              apply(vals[ia], vals[ib], vals[im], f[0], vals[iw], f[1]);
              chk(tag_of(src_a), sel_a, model(src_a));
              chk(tag_of(src_b), sel_b, model(src_b));
            end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule